// File: doc/BRIEF.md
# Split Read Completion Packet Generator

This block sits on the target side of a flash-access channel and answers host requests with completion packets. One accepted request either asks for read data or asks for a single completion without data. Read requests are limited by a maximum read size. A read that fits within the programmable maximum payload size goes out as one packet. A longer read is cut into a chain of packets. Each packet has a four-byte header followed by payload bytes taken from an input byte stream.

Packets leave on a byte stream that marks the final byte of each packet. Two handshake flags coordinate with the transmit queue. The transmit-available flag is set by the block once a packet has been fully pushed, and an external pulse clears it when the queue has taken the packet. The non-posted-free flag is dropped when a request is accepted and raised again once the request's final completion has been queued. If the queue fails to drain in time, the request ends with a busy error.

Top module: `cmpl_splitter`

## Requirements
- R1: A read request (`req_kind` = 0) whose length is no greater than `cfg_max_pl` and within the read limit produces exactly one packet of type 0x0F carrying all `req_len` bytes. This includes a length of 0, which gives a header-only packet.
- R2: A read request longer than `cfg_max_pl` (and within the read limit) produces one packet of type 0x09, then zero or more of type 0x0B, then one of type 0x0D. Every packet except the final one carries exactly `cfg_max_pl` bytes, and the final one carries the remainder.
- R3: Every packet begins with four header bytes: (3 + payload length) modulo 256; the type code; the tag in bits 7:4 with payload length bits 11:8 in bits 3:0; and payload length bits 7:0. The payload bytes follow in the order they were taken from the input stream. `out_last` is high only on the final byte of each packet, and a byte that is held back by `out_ready` low keeps its value.
- R4: The read limit is 32 shifted left by an effective size. The effective size is `cfg_req_size`, unless that exceeds `cfg_sup_size`; in that case it is `cfg_sup_size`, with a value of 0 read as 1. A read whose length equals the limit is served normally.
- R5: A read longer than the read limit takes no input bytes and produces a single header-only packet of type 0x0E.
- R6: `req_kind` = 1 produces a single header-only packet of type 0x06. `req_kind` = 2 or 3 produces a single header-only packet of type 0x0E. Neither takes input bytes.
- R7: A packet's first byte is offered only while `tx_avail` is low. `tx_avail` rises once after each packet has been fully accepted, and falls on the cycle after `tx_consumed`.
- R8: `np_free` (high after reset) falls when a request is accepted. It stays low between the packets of a split read, and rises once, together with `done`, after the final packet of the request has been queued.
- R9: If `tx_avail` stays high for TIMEOUT cycles while the next packet is waiting, the request ends with `done` and `err` both high. No further packet is sent and `np_free` stays low.
- R10: `done` pulses for exactly one cycle at the end of every request. `err` is low unless a timeout occurred. `req_ready` is high only while the block is idle.
- R11: After reset: `req_ready` = 1, `tx_avail` = 0, `np_free` = 1, `out_valid` = 0, `done` = 0, `err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_kind | input | 2 | 0 read, 1 success without data, 2/3 failure without data |
| req_tag | input | 4 | Request tag copied into every header |
| req_len | input | LEN_W | Total read length in bytes |
| cfg_max_pl | input | PL_W | Maximum payload bytes per packet (non-zero) |
| cfg_req_size | input | SZ_W | Requested read-size code |
| cfg_sup_size | input | SZ_W | Supported read-size code |
| in_valid | input | 1 | Read data byte available |
| in_ready | output | 1 | Read data byte taken this cycle |
| in_data | input | 8 | Read data byte |
| out_valid | output | 1 | Packet byte valid |
| out_ready | input | 1 | Downstream takes the packet byte |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the current packet |
| tx_avail | output | 1 | A queued packet awaits consumption |
| tx_consumed | input | 1 | Pulse: the queued packet was consumed |
| np_free | output | 1 | Ready for the next non-posted request |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Busy error, valid with `done` |

## Verification
Read lengths are chosen at the payload boundary, just above it, and at exact and inexact multiples of it, so that a single packet, a first/last pair and first/middle/last chains can each be told apart. Every pairing of requested and supported size codes from 0 to 3 is swept with lengths equal to the limit and one above it. This separates a correct choice of effective size from an off-by-one, and shows where rejection starts. Lengths above 255 and a 4096-byte read check the upper length nibble and the wrap of the length byte. Random stalls on both streams and random queue-consumption delays check the drain wait, and a queue that never drains provokes the busy error.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

  // request kinds seen on req_kind
  typedef enum logic [1:0] {
    K_READ   = 2'd0,
    K_NODATA = 2'd1,
    K_FAIL   = 2'd2,
    K_FAIL2  = 2'd3
  } req_kind_e;

  // sequencer states
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_HDR  = 3'd2,
    S_PAY  = 3'd3,
    S_ENQ  = 3'd4
  } gen_state_e;

  localparam int HDR_BYTES = 4;

endpackage

// File: rtl/cmpl_limit.sv
module cmpl_limit #(
  parameter int LEN_W = 13,
  parameter int SZ_W  = 3
) (
  input  logic [SZ_W-1:0]  req_size,
  input  logic [SZ_W-1:0]  sup_size,
  input  logic [LEN_W-1:0] len,
  output logic             over
);

  localparam int RD_W = 6 + (1 << SZ_W) - 1;
  localparam int CW   = (RD_W > LEN_W) ? RD_W : LEN_W;

  logic [SZ_W-1:0] eff;
  logic [RD_W-1:0] max_rd;

  always_comb begin
    if (req_size > sup_size) begin
      eff = (sup_size == '0) ? SZ_W'(1) : sup_size;
    end else begin
      eff = req_size;
    end
  end

  assign max_rd = RD_W'(32) << eff;
  assign over   = CW'(len) > CW'(max_rd);

endmodule

// File: rtl/cmpl_hdr.sv
module cmpl_hdr #(
  parameter int LEN_W   = 13,
  parameter int HDR_LEN = 3
) (
  input  logic [1:0]       idx,
  input  logic [LEN_W-1:0] pl,
  input  logic [7:0]       ctype,
  input  logic [3:0]       tag,
  output logic [7:0]       hbyte
);

  localparam logic [7:0] HL = 8'(HDR_LEN);

  logic [11:0] pl12;
  assign pl12 = 12'(pl);

  always_comb begin
    unique case (idx)
      2'd0:    hbyte = HL + pl12[7:0];
      2'd1:    hbyte = ctype;
      2'd2:    hbyte = {tag, pl12[11:8]};
      default: hbyte = pl12[7:0];
    endcase
  end

endmodule

// File: rtl/cmpl_timer.sv
module cmpl_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/cmpl_splitter.sv
module cmpl_splitter import cmpl_pkg::*; #(
  parameter int         LEN_W     = 13,
  parameter int         PL_W      = 12,
  parameter int         SZ_W      = 3,
  parameter int         TIMEOUT   = 4096,
  parameter int         HDR_LEN   = 3,
  parameter logic [7:0] T_OK_ND   = 8'h06,
  parameter logic [7:0] T_FIRST   = 8'h09,
  parameter logic [7:0] T_MID     = 8'h0B,
  parameter logic [7:0] T_LAST    = 8'h0D,
  parameter logic [7:0] T_ONLY    = 8'h0F,
  parameter logic [7:0] T_FAIL_ND = 8'h0E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [3:0]       req_tag,
  input  logic [LEN_W-1:0] req_len,
  input  logic [PL_W-1:0]  cfg_max_pl,
  input  logic [SZ_W-1:0]  cfg_req_size,
  input  logic [SZ_W-1:0]  cfg_sup_size,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             tx_avail,
  input  logic             tx_consumed,
  output logic             np_free,
  output logic             done,
  output logic             err
);

  localparam logic [1:0] HDR_END = 2'(HDR_BYTES - 1);

  gen_state_e       state;
  logic [1:0]       hidx;
  logic [3:0]       tag_q;
  logic [7:0]       type_q;
  logic [LEN_W-1:0] pl_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] cnt_q;
  logic             more_q;

  logic [LEN_W-1:0] mp_w;
  logic             req_over;
  logic             req_fits;
  logic             rem_fits;
  logic             slot_ok;
  logic             tmo;
  logic             wait_busy;
  logic [7:0]       hdr_byte;
  logic             is_read;

  assign mp_w      = LEN_W'(cfg_max_pl);
  assign req_fits  = req_len <= mp_w;
  assign rem_fits  = rem_q <= mp_w;
  assign slot_ok   = !out_valid || out_ready;
  assign in_ready  = (state == S_PAY) && slot_ok;
  assign req_ready = (state == S_IDLE);
  assign wait_busy = (state == S_WAIT) && tx_avail;
  assign is_read   = (req_kind == K_READ);

  cmpl_limit #(.LEN_W(LEN_W), .SZ_W(SZ_W)) u_limit (
    .req_size (cfg_req_size),
    .sup_size (cfg_sup_size),
    .len      (req_len),
    .over     (req_over)
  );

  cmpl_hdr #(.LEN_W(LEN_W), .HDR_LEN(HDR_LEN)) u_hdr (
    .idx   (hidx),
    .pl    (pl_q),
    .ctype (type_q),
    .tag   (tag_q),
    .hbyte (hdr_byte)
  );

  cmpl_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (wait_busy),
    .expired (tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      hidx      <= '0;
      tag_q     <= '0;
      type_q    <= '0;
      pl_q      <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      more_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      tx_avail  <= 1'b0;
      np_free   <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (tx_consumed) tx_avail <= 1'b0;

      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            tag_q   <= req_tag;
            np_free <= 1'b0;
            hidx    <= '0;
            state   <= S_WAIT;
            if (is_read && !req_over) begin
              if (req_fits) begin
                type_q <= T_ONLY;
                pl_q   <= req_len;
                rem_q  <= '0;
                more_q <= 1'b0;
              end else begin
                type_q <= T_FIRST;
                pl_q   <= mp_w;
                rem_q  <= req_len - mp_w;
                more_q <= 1'b1;
              end
            end else begin
              type_q <= (req_kind == K_NODATA) ? T_OK_ND : T_FAIL_ND;
              pl_q   <= '0;
              rem_q  <= '0;
              more_q <= 1'b0;
            end
          end
        end

        S_WAIT: begin
          if (!tx_avail) begin
            state <= S_HDR;
            hidx  <= '0;
          end else if (tmo) begin
            done  <= 1'b1;
            err   <= 1'b1;
            state <= S_IDLE;
          end
        end

        S_HDR: begin
          if (slot_ok) begin
            out_valid <= 1'b1;
            out_data  <= hdr_byte;
            out_last  <= (hidx == HDR_END) && (pl_q == '0);
            hidx      <= hidx + 2'd1;
            if (hidx == HDR_END) begin
              cnt_q <= pl_q;
              state <= (pl_q == '0) ? S_ENQ : S_PAY;
            end
          end
        end

        S_PAY: begin
          if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_last  <= (cnt_q == LEN_W'(1));
            cnt_q     <= cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) state <= S_ENQ;
          end
        end

        S_ENQ: begin
          if (!out_valid) begin
            tx_avail <= 1'b1;
            if (more_q) begin
              if (rem_fits) begin
                type_q <= T_LAST;
                pl_q   <= rem_q;
                rem_q  <= '0;
                more_q <= 1'b0;
              end else begin
                type_q <= T_MID;
                pl_q   <= mp_w;
                rem_q  <= rem_q - mp_w;
                more_q <= 1'b1;
              end
              state <= S_WAIT;
            end else begin
              np_free <= 1'b1;
              done    <= 1'b1;
              state   <= S_IDLE;
            end
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // a packet header starts only once the previous packet has drained
  p_hdr_after_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_HDR && hidx == 2'd0) |-> !tx_avail);

  // a piece never exceeds the programmed payload size
  p_pl_cap_r2: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> (pl_q <= mp_w));

  // output byte held while back-pressured
  p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // non-posted-free stays low through the whole request
  p_np_low_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> !np_free);

  // release of non-posted-free coincides with a clean finish
  p_np_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(np_free) |-> (done && !err));

  // busy error only ever accompanies the end pulse
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

endmodule

// File: tb/cmpl_splitter_test.sv
module cmpl_splitter_test;

  localparam int CLK_P = 10;
  localparam int TO    = 40;
  localparam int LEN_W = 13;
  localparam int PL_W  = 12;
  localparam int SZ_W  = 3;
  localparam int MASK  = 8191;

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid;
  logic             req_ready;
  logic [1:0]       req_kind;
  logic [3:0]       req_tag;
  logic [LEN_W-1:0] req_len;
  logic [PL_W-1:0]  cfg_max_pl;
  logic [SZ_W-1:0]  cfg_req_size;
  logic [SZ_W-1:0]  cfg_sup_size;
  logic             in_valid;
  logic             in_ready;
  logic [7:0]       in_data;
  logic             out_valid;
  logic             out_ready;
  logic [7:0]       out_data;
  logic             out_last;
  logic             tx_avail;
  logic             tx_consumed;
  logic             np_free;
  logic             done;
  logic             err;

  cmpl_splitter #(.LEN_W(LEN_W), .PL_W(PL_W), .SZ_W(SZ_W), .TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_tag(req_tag), .req_len(req_len),
    .cfg_max_pl(cfg_max_pl), .cfg_req_size(cfg_req_size), .cfg_sup_size(cfg_sup_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .tx_avail(tx_avail), .tx_consumed(tx_consumed), .np_free(np_free),
    .done(done), .err(err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // monitor-owned running totals
  logic [7:0] cap_b [0:MASK];
  logic       cap_l [0:MASK];
  int  cap_total = 0;
  int  src_idx = 0;
  int  done_total = 0;
  int  np_rise_total = 0;
  int  tx_rise_total = 0;
  int  viol_total = 0;
  bit  last_err = 1'b0;
  bit  np_prev = 1'b1;
  bit  tx_prev = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // main-owned controls
  bit stall_mode = 1'b0;
  bit hold_tx = 1'b0;

  // expected stream
  logic [7:0] exp_b [0:MASK];
  logic       exp_l [0:MASK];
  int exp_n;
  int exp_pieces;
  int exp_pay;
  int exp_src;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_b(input int v);
    exp_b[exp_n] = 8'(v);
    exp_l[exp_n] = 1'b0;
    exp_n++;
  endtask

  task automatic add_piece(input int t, input int pl, input int tag, input int maxp);
    if (maxp != 0 && exp_pieces >= maxp) return;
    exp_pieces++;
    push_b((3 + pl) & 255);
    push_b(t);
    push_b((tag << 4) | ((pl >> 8) & 15));
    push_b(pl & 255);
    for (int k = 0; k < pl; k++) begin
      push_b(exp_src & 255);
      exp_src++;
    end
    exp_pay += pl;
    exp_l[exp_n-1] = 1'b1;
  endtask

  // stream drivers and monitor
  initial begin
    out_ready = 1'b0;
    in_valid = 1'b0;
    in_data = 8'd0;
    tx_consumed = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      in_valid = stall_mode ? (lfsr[1] | lfsr[4]) : 1'b1;
      in_data = 8'(src_idx);
      tx_consumed = tx_avail && !hold_tx && lfsr[2];
      #1;
      if (out_valid && out_ready) begin
        if ((cap_total == 0 || cap_l[(cap_total-1) & MASK]) && tx_avail) viol_total++;
        cap_b[cap_total & MASK] = out_data;
        cap_l[cap_total & MASK] = out_last;
        cap_total++;
      end
      if (in_valid && in_ready) src_idx++;
      if (done) begin
        done_total++;
        last_err = err;
      end
      if (np_free && !np_prev) np_rise_total++;
      np_prev = np_free;
      if (tx_avail && !tx_prev) tx_rise_total++;
      tx_prev = tx_avail;
    end
  end

  task automatic run_req(input int kind, input int tag, input int len, input int mp,
                         input int rq, input int sp, input int maxp, input string rt);
    int eff, maxrd, rem, c0, s0, d0, n0, t0, v0, mis, wait_n;
    bit stuck;
    stuck = (maxp != 0);
    eff = (rq > sp) ? ((sp == 0) ? 1 : sp) : rq;
    maxrd = 32 << eff;
    exp_n = 0; exp_pieces = 0; exp_pay = 0;
    exp_src = src_idx;
    if (kind == 1) add_piece(8'h06, 0, tag, maxp);
    else if (kind != 0 || len > maxrd) add_piece(8'h0E, 0, tag, maxp);
    else if (len <= mp) add_piece(8'h0F, len, tag, maxp);
    else begin
      rem = len;
      add_piece(8'h09, mp, tag, maxp);
      rem -= mp;
      while (rem > mp) begin
        add_piece(8'h0B, mp, tag, maxp);
        rem -= mp;
      end
      add_piece(8'h0D, rem, tag, maxp);
    end

    @(negedge clk);
    wait_n = 0;
    while (!req_ready && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    c0 = cap_total; s0 = src_idx; d0 = done_total;
    n0 = np_rise_total; t0 = tx_rise_total; v0 = viol_total;
    cfg_max_pl = PL_W'(mp);
    cfg_req_size = SZ_W'(rq);
    cfg_sup_size = SZ_W'(sp);
    req_kind = 2'(kind);
    req_tag = 4'(tag);
    req_len = LEN_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk(!req_ready, "R10", "req_ready while busy", int'(req_ready), 0);
    wait_n = 0;
    while (done_total == d0 && wait_n < 30000) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (3) @(negedge clk);
    #2;
    chk(cap_total - c0 == exp_n, rt, "byte count", cap_total - c0, exp_n);
    mis = -1;
    for (int i = 0; i < exp_n; i++) begin
      if (mis < 0 && (i < cap_total - c0) &&
          (cap_b[(c0+i) & MASK] !== exp_b[i] || cap_l[(c0+i) & MASK] !== exp_l[i])) mis = i;
    end
    if (mis >= 0)
      chk(1'b0, rt, $sformatf("byte %0d (data,last)", mis),
          {cap_b[(c0+mis) & MASK], 7'd0, cap_l[(c0+mis) & MASK]}, {exp_b[mis], 7'd0, exp_l[mis]});
    else
      chk(1'b1, rt, "stream content", 0, 0);
    chk(src_idx - s0 == exp_pay, rt, "input bytes taken", src_idx - s0, exp_pay);
    chk(done_total - d0 == 1, "R10", "done pulses", done_total - d0, 1);
    chk(last_err == stuck, stuck ? "R9" : "R10", "err", int'(last_err), int'(stuck));
    chk(np_rise_total - n0 == (stuck ? 0 : 1), "R8", "np_free rises", np_rise_total - n0, stuck ? 0 : 1);
    chk(np_free == !stuck, "R8", "np_free at end", int'(np_free), int'(!stuck));
    chk(tx_rise_total - t0 == exp_pieces, "R7", "tx_avail rises", tx_rise_total - t0, exp_pieces);
    chk(viol_total == v0, "R7", "packet start while tx_avail high", viol_total - v0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int mr, ef;
    rst = 1'b1;
    req_valid = 1'b0;
    req_kind = 2'd0;
    req_tag = 4'd0;
    req_len = '0;
    cfg_max_pl = PL_W'(64);
    cfg_req_size = SZ_W'(3);
    cfg_sup_size = SZ_W'(3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(req_ready == 1'b1, "R11", "req_ready", int'(req_ready), 1);
    chk(tx_avail == 1'b0, "R11", "tx_avail", int'(tx_avail), 0);
    chk(np_free == 1'b1, "R11", "np_free", int'(np_free), 1);
    chk(out_valid == 1'b0, "R11", "out_valid", int'(out_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R11", "done/err", int'(done | err), 0);

    // single packet cases
    run_req(0, 5, 20, 64, 3, 3, 0, "R1");
    run_req(0, 6, 64, 64, 3, 3, 0, "R1");
    run_req(0, 0, 0, 64, 3, 3, 0, "R1");
    // split chains
    run_req(0, 7, 65, 64, 3, 3, 0, "R2");
    run_req(0, 8, 128, 64, 3, 3, 0, "R2");
    run_req(0, 9, 200, 64, 3, 3, 0, "R2");
    stall_mode = 1'b1;
    run_req(0, 2, 150, 50, 3, 3, 0, "R2");
    // header length fields above one byte
    run_req(0, 10, 300, 4095, 4, 7, 0, "R3");
    run_req(0, 11, 1, 4095, 4, 7, 0, "R3");
    run_req(0, 12, 4096, 4095, 7, 7, 0, "R3");
    // size code sweep: limit exact and one above
    for (int rq = 0; rq < 4; rq++) begin
      for (int sp = 0; sp < 4; sp++) begin
        ef = (rq > sp) ? ((sp == 0) ? 1 : sp) : rq;
        mr = 32 << ef;
        run_req(0, (rq * 4 + sp) & 15, mr, 48, rq, sp, 0, "R4");
        run_req(0, (rq * 4 + sp + 1) & 15, mr + 1, 48, rq, sp, 0, "R5");
      end
    end
    stall_mode = 1'b0;
    // no-data kinds
    run_req(1, 3, 100, 64, 3, 3, 0, "R6");
    run_req(2, 4, 10, 64, 3, 3, 0, "R6");
    run_req(3, 15, 10, 64, 3, 3, 0, "R6");
    // queue never drains after first piece
    hold_tx = 1'b1;
    run_req(0, 13, 100, 40, 3, 3, 1, "R9");
    hold_tx = 1'b0;
    repeat (20) @(negedge clk);
    #2;
    chk(tx_avail == 1'b0, "R7", "tx_avail after consume", int'(tx_avail), 0);
    // normal operation resumes
    run_req(0, 14, 90, 40, 3, 3, 0, "R8");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule